// File: doc/BRIEF.md
# Outstanding memory counter tracker

This block keeps a running count of memory and export operations that one wavefront has issued and that have not yet completed. It holds three independent counters: one for vector memory traffic, one for export traffic, and one for the combined local, global, constant and message traffic (LGKM). Each accepted issue names one instruction class as a one-hot vector. The block then increments every counter that class is charged to. Each counter has its own completion pulse, which decrements it by one.

A scheduler that must wait for older operations presents three thresholds on the wait-request port. From that cycle the stall output stays high until every counter has fallen to its threshold or below. The stall output is combinational from the counters, so it drops in the same cycle in which the last needed decrement is stored.

Counters saturate instead of wrapping. Illegal increments and decrements are reported through two sticky error flags.

Top module: `mem_pending_tracker`

## Requirements
- R1: An accepted issue of class bit 0 (scalar memory read) or bit 1 (local data share) raises only the LGKM counter by one.
- R2: An accepted issue of class bit 2 (untyped buffer), bit 3 (typed buffer) or bit 4 (image) raises both the vector-memory counter and the export counter by one, and leaves the LGKM counter unchanged.
- R3: An accepted issue of class bit 5 (flat) raises both the vector-memory counter and the LGKM counter by one. A wait with zero thresholds placed after a flat issue stalls until both counters have been decremented.
- R4: An issue is accepted only when `issue_valid` is high and `issue_class` has exactly one bit set. Any other issue changes no counter.
- R5: A completion pulse on a counter with a non-zero value lowers that counter by one on the next clock edge.
- R6: When an accepted issue and a completion reach the same counter in the same cycle, that counter keeps its value and neither error flag is raised by it.
- R7: A counter at its maximum value (15, 7 and 31 for vector-memory, export and LGKM with default widths) that receives an increment without a completion keeps its value, and `overflow_err` is set and stays set until reset.
- R8: A completion on a counter at zero without an increment leaves the counter at zero, and `underflow_err` is set and stays set until reset.
- R9: `stall` is high in the cycle in which `wait_valid` is high if any counter exceeds its threshold. It stays high, using the stored thresholds, until every counter is at or below its threshold. It falls in the cycle in which that becomes true and stays low until the next wait request.
- R10: Synchronous active-high reset clears all counters, both error flags and any pending wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_class | input | 6 | One-hot class: 0 scalar mem, 1 local share, 2 untyped buf, 3 typed buf, 4 image, 5 flat |
| vm_done | input | 1 | One vector-memory operation completed |
| exp_done | input | 1 | One export operation completed |
| lgk_done | input | 1 | One LGKM operation completed |
| wait_valid | input | 1 | New wait request with the thresholds below |
| wait_vm | input | VM_W | Vector-memory threshold |
| wait_exp | input | EXP_W | Export threshold |
| wait_lgk | input | LGK_W | LGKM threshold |
| stall | output | 1 | A wait is pending and a counter is above its threshold |
| vm_cnt | output | VM_W | Pending vector-memory count |
| exp_cnt | output | EXP_W | Pending export count |
| lgk_cnt | output | LGK_W | Pending LGKM count |
| overflow_err | output | 1 | Sticky: an increment hit a full counter |
| underflow_err | output | 1 | Sticky: a completion hit an empty counter |

## Verification
An issue and a completion can reach the same counter in the same cycle. The bench provokes this directly, with a buffer issue together with a vector-memory completion, and at random, where issue and completion pulses are drawn independently every cycle. These collisions also occur at a full and at an empty counter. In each case the expected value comes from a bench model: the counter must hold and no error flag may change. The second overlap is a wait request in the cycle in which a decrement lands. Random wait requests are mixed with completions, and the bench judges the stall level in each cycle from the model's counts and its stored thresholds.

// File: rtl/mem_pending_tracker.sv
module mem_pending_tracker #(
  parameter int VM_W  = 4,
  parameter int EXP_W = 3,
  parameter int LGK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [5:0]       issue_class,
  input  logic             vm_done,
  input  logic             exp_done,
  input  logic             lgk_done,
  input  logic             wait_valid,
  input  logic [VM_W-1:0]  wait_vm,
  input  logic [EXP_W-1:0] wait_exp,
  input  logic [LGK_W-1:0] wait_lgk,
  output logic             stall,
  output logic [VM_W-1:0]  vm_cnt,
  output logic [EXP_W-1:0] exp_cnt,
  output logic [LGK_W-1:0] lgk_cnt,
  output logic             overflow_err,
  output logic             underflow_err
);
  localparam logic [VM_W-1:0]  VM_MAX  = {VM_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic [LGK_W-1:0] LGK_MAX = {LGK_W{1'b1}};

  logic accept, vm_inc, exp_inc, lgk_inc;
  assign accept  = issue_valid && $onehot(issue_class);
  assign lgk_inc = accept && (issue_class[0] || issue_class[1] || issue_class[5]);
  assign exp_inc = accept && (issue_class[2] || issue_class[3] || issue_class[4]);
  assign vm_inc  = exp_inc || (accept && issue_class[5]);

  logic vm_up, vm_dn, exp_up, exp_dn, lgk_up, lgk_dn;
  assign vm_up  = vm_inc  && !vm_done;
  assign vm_dn  = vm_done && !vm_inc;
  assign exp_up = exp_inc && !exp_done;
  assign exp_dn = exp_done && !exp_inc;
  assign lgk_up = lgk_inc && !lgk_done;
  assign lgk_dn = lgk_done && !lgk_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      vm_cnt  <= '0;
      exp_cnt <= '0;
      lgk_cnt <= '0;
    end else begin
      if (vm_up && vm_cnt != VM_MAX)        vm_cnt <= vm_cnt + 1'b1;
      else if (vm_dn && vm_cnt != '0)       vm_cnt <= vm_cnt - 1'b1;
      if (exp_up && exp_cnt != EXP_MAX)     exp_cnt <= exp_cnt + 1'b1;
      else if (exp_dn && exp_cnt != '0)     exp_cnt <= exp_cnt - 1'b1;
      if (lgk_up && lgk_cnt != LGK_MAX)     lgk_cnt <= lgk_cnt + 1'b1;
      else if (lgk_dn && lgk_cnt != '0)     lgk_cnt <= lgk_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow_err  <= 1'b0;
      underflow_err <= 1'b0;
    end else begin
      if ((vm_up && vm_cnt == VM_MAX) || (exp_up && exp_cnt == EXP_MAX) ||
          (lgk_up && lgk_cnt == LGK_MAX))
        overflow_err <= 1'b1;
      if ((vm_dn && vm_cnt == '0) || (exp_dn && exp_cnt == '0) ||
          (lgk_dn && lgk_cnt == '0))
        underflow_err <= 1'b1;
    end
  end

  logic             wait_active;
  logic [VM_W-1:0]  thr_vm;
  logic [EXP_W-1:0] thr_exp;
  logic [LGK_W-1:0] thr_lgk;
  logic [VM_W-1:0]  sel_vm;
  logic [EXP_W-1:0] sel_exp;
  logic [LGK_W-1:0] sel_lgk;
  logic             above;

  assign sel_vm  = wait_valid ? wait_vm  : thr_vm;
  assign sel_exp = wait_valid ? wait_exp : thr_exp;
  assign sel_lgk = wait_valid ? wait_lgk : thr_lgk;
  assign above   = (vm_cnt > sel_vm) || (exp_cnt > sel_exp) || (lgk_cnt > sel_lgk);
  assign stall   = (wait_valid || wait_active) && above;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_active <= 1'b0;
      thr_vm      <= '0;
      thr_exp     <= '0;
      thr_lgk     <= '0;
    end else begin
      wait_active <= stall;
      if (wait_valid) begin
        thr_vm  <= wait_vm;
        thr_exp <= wait_exp;
        thr_lgk <= wait_lgk;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (vm_cnt == '0 && exp_cnt == '0 && lgk_cnt == '0 && !overflow_err && !underflow_err && !stall)); // R10
  AST_FLAT_BOTH: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_class == 6'b100000 && !vm_done && !lgk_done && vm_cnt != VM_MAX && lgk_cnt != LGK_MAX)
    |=> (vm_cnt == $past(vm_cnt) + 1'b1 && lgk_cnt == $past(lgk_cnt) + 1'b1)); // R3
  AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vm_inc && vm_done) |=> $stable(vm_cnt)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (vm_cnt == VM_MAX && vm_inc && !vm_done) |=> (vm_cnt == VM_MAX && overflow_err)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (lgk_cnt == '0 && lgk_done && !lgk_inc) |=> (lgk_cnt == '0 && underflow_err)); // R8
  AST_STICKY_OVF: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err); // R7
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (vm_cnt == '0 && exp_cnt == '0 && lgk_cnt == '0) |-> !stall); // R9
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (rst)
    (!$onehot(issue_class) && !vm_done && !exp_done && !lgk_done)
    |=> ($stable(vm_cnt) && $stable(exp_cnt) && $stable(lgk_cnt))); // R4
endmodule

// File: tb/tb_mem_pending_tracker.sv
`timescale 1ns/1ps
module tb_mem_pending_tracker;
  logic clk = 0, rst = 1;
  logic iv = 0, vd = 0, ed = 0, ld = 0, wv = 0;
  logic [5:0] cls = 0;
  logic [3:0] tv = 0;
  logic [2:0] te = 0;
  logic [4:0] tl = 0;
  logic stall, ovf, unf;
  logic [3:0] vmc;
  logic [2:0] exc;
  logic [4:0] lgc;
  int checks = 0, fails = 0;
  int m_vm, m_ex, m_lg, m_ovf, m_unf, m_wact, m_tv, m_te, m_tl;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  mem_pending_tracker dut (.clk(clk), .rst(rst), .issue_valid(iv), .issue_class(cls),
    .vm_done(vd), .exp_done(ed), .lgk_done(ld), .wait_valid(wv), .wait_vm(tv),
    .wait_exp(te), .wait_lgk(tl), .stall(stall), .vm_cnt(vmc), .exp_cnt(exc),
    .lgk_cnt(lgc), .overflow_err(ovf), .underflow_err(unf));

  function automatic int step_cnt(int c, bit inc, bit dec, int mx, ref int o, ref int u);
    if (inc && !dec) begin if (c == mx) o = 1; else return c + 1; end
    else if (dec && !inc) begin if (c == 0) u = 1; else return c - 1; end
    return c;
  endfunction

  function automatic bit exp_stall();
    int a, b, c;
    a = wv ? int'(tv) : m_tv; b = wv ? int'(te) : m_te; c = wv ? int'(tl) : m_tl;
    return (wv || m_wact) && (m_vm > a || m_ex > b || m_lg > c);
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    m_vm = 0; m_ex = 0; m_lg = 0; m_ovf = 0; m_unf = 0; m_wact = 0; m_tv = 0; m_te = 0; m_tl = 0;
  endtask

  task automatic cyc(bit i_v, logic [5:0] c, bit a, bit b, bit d, bit w,
                     int t0, int t1, int t2, string tag);
    bit acc, vi, ei, li, st;
    @(negedge clk);
    iv = i_v; cls = c; vd = a; ed = b; ld = d; wv = w;
    tv = t0[3:0]; te = t1[2:0]; tl = t2[4:0];
    #1;
    chk({tag, " vm_cnt"}, int'(vmc), m_vm);
    chk({tag, " exp_cnt"}, int'(exc), m_ex);
    chk({tag, " lgk_cnt"}, int'(lgc), m_lg);
    chk({tag, " overflow"}, int'(ovf), m_ovf);
    chk({tag, " underflow"}, int'(unf), m_unf);
    st = exp_stall();
    chk({tag, " stall"}, int'(stall), int'(st));
    acc = i_v && $countones(c) == 1;
    li = acc && (c[0] || c[1] || c[5]);
    ei = acc && (c[2] || c[3] || c[4]);
    vi = ei || (acc && c[5]);
    m_vm = step_cnt(m_vm, vi, a, 15, m_ovf, m_unf);
    m_ex = step_cnt(m_ex, ei, b, 7, m_ovf, m_unf);
    m_lg = step_cnt(m_lg, li, d, 31, m_ovf, m_unf);
    m_wact = st;
    if (w) begin m_tv = t0; m_te = t1; m_tl = t2; end
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; iv = 0; vd = 0; ed = 0; ld = 0; wv = 0;
    @(negedge clk);
    rst = 0; model_reset();
  endtask

  initial begin
    #1ms;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(negedge clk);
    rst = 0;
    idle("R10 reset state");
    // R1 scalar mem and local share
    cyc(1, 6'b000001, 0, 0, 0, 0, 0, 0, 0, "R10 pre");
    cyc(1, 6'b000010, 0, 0, 0, 0, 0, 0, 0, "R1 smem");
    // R2 buffers and image
    cyc(1, 6'b000100, 0, 0, 0, 0, 0, 0, 0, "R1 lds");
    cyc(1, 6'b001000, 0, 0, 0, 0, 0, 0, 0, "R2 ubuf");
    cyc(1, 6'b010000, 0, 0, 0, 0, 0, 0, 0, "R2 tbuf");
    // R4 illegal classes
    cyc(1, 6'b000011, 0, 0, 0, 0, 0, 0, 0, "R2 image");
    cyc(1, 6'b000000, 0, 0, 0, 0, 0, 0, 0, "R4 two-hot");
    cyc(0, 6'b100000, 0, 0, 0, 0, 0, 0, 0, "R4 zero class");
    // R6 collision on vm: buffer issue + vm_done
    cyc(1, 6'b000100, 1, 0, 0, 0, 0, 0, 0, "R4 valid low");
    // R5 decrement each
    cyc(0, 0, 1, 1, 1, 0, 0, 0, 0, "R6 collide");
    idle("R5 decrement");
    // R9 wait: vm=2 exp=3 lgk=1 ; wait vm<=0, exp<=7, lgk<=31
    cyc(0, 0, 0, 0, 0, 1, 0, 7, 31, "R5 settle");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 stall raised");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 stall held");
    idle("R9 stall drops");
    idle("R9 stays low");
    // R3 flat: fresh state
    do_reset();
    idle("R10 after reset");
    cyc(1, 6'b100000, 0, 0, 0, 0, 0, 0, 0, "R10 pre flat");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3 flat charge");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 flat waiting");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 flat vm drained");
    idle("R3 flat both drained");
    // R8 underflow
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 idle");
    idle("R8 underflow");
    // R7 overflow via export counter
    for (int k = 0; k < 9; k++) cyc(1, 6'b010000, 0, 0, 0, 0, 0, 0, 0, "R7 fill");
    idle("R7 saturated");
    cyc(1, 6'b010000, 0, 1, 0, 0, 0, 0, 0, "R7 sticky");
    idle("R6 collide at max");
    do_reset();
    idle("R10 flags cleared");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit i_v, a, b, d, w;
      logic [5:0] c;
      int r;
      i_v = ($urandom % 100) < 45;
      r = $urandom % 10;
      c = (r < 8) ? (6'b1 << ($urandom % 6)) : 6'($urandom);
      a = ($urandom % 100) < 35;
      b = ($urandom % 100) < 25;
      d = ($urandom % 100) < 30;
      w = ($urandom % 100) < 8;
      cyc(i_v, c, a, b, d, w, $urandom % 16, $urandom % 8, $urandom % 32, "R5 random");
      if (n % 1000 == 999) do_reset();
    end
    idle("R9 random final");
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule